// File: doc/BRIEF.md
# Mode-Configurable Multiply-Accumulate Slice

This block is a signed two's-complement arithmetic slice for filter and transform datapaths. One shared set of parallel multipliers feeds a result stage that each half of the slice configures on its own: the half can output plain products, run a 52-bit accumulator, add or subtract pairs of products, or add four products. Complex products come from the pair mode. With subtraction enabled, a pair gives the real part of a complex product, and without it the pair gives the imaginary part.

The operand width `OP_W` is fixed when the block is built and can be 9, 18 or 36. The number of multipliers follows from it: eight at 9 bits, four at 18 bits and one at 36 bits. At 36 bits the slice only multiplies, and the mode, subtract and clear inputs have no effect.

The A operand registers can be chained into a tap delay line for FIR filters. The chain enters through a cascade input, and the last tap drives a cascade output that feeds the next slice. The pipeline has three register stages: operands, products and results. A valid flag travels with the data.

Top module: `mac_slice`

## Requirements
- R1: After reset, `out_valid` is 0, `result` is all zeros and `casc_out` is 0.
- R2: `out_valid` equals `in_valid` as sampled three clock edges earlier, and the result of that input is on `result` in the same cycle.
- R3: Mode code 0 (multiply): lane k of `result`, at bits [k·2·OP_W +: 2·OP_W], holds the signed product of A lane k and B lane k. Operand lane k is at bits [k·OP_W +: OP_W].
- R4: Mode code 1 (accumulate): the half adds the product of its lowest lane to a 52-bit accumulator that wraps modulo 2^52. The low half uses lane 0 and the high half uses lane N/2. The sum is sign-extended into that half of `result`, which is bits [0 +: 72] for the low half and [72 +: 72] for the high half.
- R5: When the half's bit of `acc_clr` is 1 on a valid accumulate input, the accumulator loads that product instead of adding it.
- R6: Mode code 2 (pair add): each lane pair (2j, 2j+1) of the half gives P2j + P2j+1. When the half's `sub_en` bit is 1 it gives P2j − P2j+1 instead. The result is sign-extended over both lanes of the pair.
- R7: Mode code 3 (four-product add) gives P0 ± P1 + P2 ± P3. The subtract signs follow R6. At 9 bits each half forms its own sum of four. At 18 bits, code 3 on `mode_lo` takes the whole slice: the sum is sign-extended over all 144 bits, and `mode_hi`, `sub_en[1]` and `acc_clr[1]` have no effect. Code 3 on `mode_hi` alone leaves the high half of `result` unchanged.
- R8: The two halves run their modes independently in the same cycle. `mode_lo`, `sub_en[0]` and `acc_clr[0]` control the low half, and `mode_hi`, `sub_en[1]` and `acc_clr[1]` control the high half.
- R9: With `chain_en` at 1, every clock loads tap 0 from `casc_in` and tap k from tap k−1, and `a_in` has no effect. `casc_out` shows the last tap.
- R10: An input with `in_valid` at 0 changes neither `result` nor the accumulators.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_lo | input | 2 | Mode of the low half (0 multiply, 1 accumulate, 2 pair add, 3 four-product add) |
| mode_hi | input | 2 | Mode of the high half |
| sub_en | input | 2 | Per-half subtract of the second product in each pair |
| acc_clr | input | 2 | Per-half accumulator load |
| chain_en | input | 1 | Selects the tap shift chain for the A operands |
| in_valid | input | 1 | Input operands are valid |
| a_in | input | N·OP_W | A operand lanes |
| b_in | input | N·OP_W | B operand lanes |
| casc_in | input | OP_W | Chain input to tap 0 |
| casc_out | output | OP_W | Chain output from the last tap |
| out_valid | output | 1 | Result is valid |
| result | output | N·2·OP_W | Result lanes |

## Verification
Random operands are mixed with the extreme values, the most negative value, the most positive value, zero and minus one. The extremes expose sign-extension and product-width errors that random values rarely hit. Each mode runs in its own phase: multiply checks the lane placement, accumulate with random clears separates the loading of a product from the adding of one, and pair add with random subtract separates the real-part sign from the imaginary-part sign. Four-product add runs with a random `mode_hi`, which shows that the low half owns the whole slice. A mixed phase shows that the halves do not disturb each other. The chain phase feeds `casc_in` while `a_in` is random, which tells a true delay line apart from parallel loading. Gaps in `in_valid` show that the output and the accumulators hold.

// File: rtl/mac_slice_pkg.sv
// Shared types for the multiply-accumulate slice.
// Assumes two halves per slice and a fixed 52-bit accumulator.
package mac_slice_pkg;
    typedef enum logic [1:0] {
        MD_MUL  = 2'd0,
        MD_MAC  = 2'd1,
        MD_ADD2 = 2'd2,
        MD_ADD4 = 2'd3
    } md_e;

    typedef struct packed {
        logic       vld;
        md_e        m_lo;
        md_e        m_hi;
        logic [1:0] sub;
        logic [1:0] clr;
    } ctl_t;

    localparam int ACC_W = 52;

    // Number of parallel multipliers for a given operand width.
    function automatic int mults_for(input int w);
        return (w == 9) ? 8 : (w == 18) ? 4 : 1;
    endfunction
endpackage

// File: rtl/mac_slice_in.sv
// Operand input stage: registers the A and B lanes and the control word.
// When chain_en is 1, the A registers form a delay line fed from casc_in.
// Assumes chain_en is static or changed only between uses.
module mac_slice_in
    import mac_slice_pkg::*;
#(
    parameter int W = 18,
    parameter int N = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           chain_en,
    input  logic [N*W-1:0] a_in,
    input  logic [N*W-1:0] b_in,
    input  logic [W-1:0]   casc_in,
    input  ctl_t           ctl_in,
    output logic [N*W-1:0] a_q,
    output logic [N*W-1:0] b_q,
    output ctl_t           ctl_q,
    output logic [W-1:0]   casc_out
);
    logic [N*W-1:0] a_nxt;

    // Select the source of each tap: parallel load or the previous tap.
    for (genvar k = 0; k < N; k++) begin : g_tap
        if (k == 0) begin : g_first
            assign a_nxt[W-1:0] = chain_en ? casc_in : a_in[W-1:0];
        end else begin : g_next
            assign a_nxt[k*W +: W] = chain_en ? a_q[(k-1)*W +: W] : a_in[k*W +: W];
        end
    end

    // Capture the operands and the control word on every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q   <= '0;
            b_q   <= '0;
            ctl_q <= '0;
        end else begin
            a_q   <= a_nxt;
            b_q   <= b_in;
            ctl_q <= ctl_in;
        end
    end

    assign casc_out = a_q[(N-1)*W +: W];
endmodule

// File: rtl/mac_slice_mul.sv
// Product stage: one signed multiplier per lane, with a registered output.
// Assumes the operands are two's complement of width W.
module mac_slice_mul
    import mac_slice_pkg::*;
#(
    parameter int W = 18,
    parameter int N = 4,
    localparam int PW = 2 * W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N*W-1:0]  a_q,
    input  logic [N*W-1:0]  b_q,
    input  ctl_t            ctl_in,
    output logic [N*PW-1:0] p_q,
    output ctl_t            ctl_q
);
    for (genvar k = 0; k < N; k++) begin : g_mul
        logic signed [PW-1:0] prod;
        assign prod = $signed(a_q[k*W +: W]) * $signed(b_q[k*W +: W]);

        // Register the product of lane k.
        always_ff @(posedge clk) begin
            if (!rst_n) p_q[k*PW +: PW] <= '0;
            else        p_q[k*PW +: PW] <= prod;
        end
    end

    // Carry the control word alongside the products.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_in;
    end
endmodule

// File: rtl/mac_slice_out.sv
// Result stage: builds products, pair sums, four-product sums or accumulator
// values into the result register, separately for each half.
// Assumes N is 8, 4 or 1. At N == 1 only the plain product is produced.
module mac_slice_out
    import mac_slice_pkg::*;
#(
    parameter int W = 18,
    parameter int N = 4,
    localparam int PW    = 2 * W,
    localparam int OUT_W = N * PW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N*PW-1:0]  p_q,
    input  ctl_t             ctl,
    output logic [OUT_W-1:0] res_q,
    output logic             vld_q
);
    // Track validity to the output.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= 1'b0;
        else        vld_q <= ctl.vld;
    end

    if (N == 1) begin : g_wide
        // Wide operands: plain product only.
        always_ff @(posedge clk) begin
            if (!rst_n)       res_q <= '0;
            else if (ctl.vld) res_q <= p_q;
        end
    end else begin : g_split
        localparam int LPH = N / 2;
        localparam int HW  = OUT_W / 2;

        logic signed [PW-1:0]    pl [N];
        logic signed [ACC_W-1:0] acc_q [2];
        logic signed [ACC_W-1:0] acc_n [2];
        logic [OUT_W-1:0]        res_n;

        for (genvar k = 0; k < N; k++) begin : g_lane
            assign pl[k] = $signed(p_q[k*PW +: PW]);
        end

        // Build the next result and the next accumulator values.
        always_comb begin
            logic signed [OUT_W-1:0] s;
            logic signed [OUT_W-1:0] ew;
            logic signed [ACC_W-1:0] e52;
            logic                    full4;
            md_e                     md;
            logic                    sb;
            int                      base;
            res_n    = res_q;
            acc_n[0] = acc_q[0];
            acc_n[1] = acc_q[1];
            full4    = (LPH == 2) && (ctl.m_lo == MD_ADD4);
            if (ctl.vld) begin
                for (int h = 0; h < 2; h++) begin
                    md   = (h == 0) ? ctl.m_lo : ctl.m_hi;
                    sb   = ctl.sub[h];
                    base = h * LPH;
                    if (!(full4 && h == 1)) begin
                        case (md)
                            MD_MUL: begin
                                for (int j = 0; j < LPH; j++)
                                    res_n[(base+j)*PW +: PW] = pl[base+j];
                            end
                            MD_MAC: begin
                                e52      = pl[base];
                                acc_n[h] = ctl.clr[h] ? e52 : acc_q[h] + e52;
                                ew       = acc_n[h];
                                res_n[h*HW +: HW] = ew[HW-1:0];
                            end
                            MD_ADD2: begin
                                for (int j = 0; j < LPH/2; j++) begin
                                    s  = pl[base+2*j];
                                    ew = pl[base+2*j+1];
                                    s  = sb ? s - ew : s + ew;
                                    res_n[(base+2*j)*PW +: 2*PW] = s[2*PW-1:0];
                                end
                            end
                            default: begin
                                if (LPH == 4) begin
                                    s = '0;
                                    for (int j = 0; j < 4; j++) begin
                                        ew = pl[base+j];
                                        s  = (sb && (j % 2 == 1)) ? s - ew : s + ew;
                                    end
                                    res_n[h*HW +: HW] = s[HW-1:0];
                                end
                            end
                        endcase
                    end
                end
                if (full4) begin
                    s = '0;
                    for (int j = 0; j < LPH*2; j++) begin
                        ew = pl[j];
                        s  = (ctl.sub[0] && (j % 2 == 1)) ? s - ew : s + ew;
                    end
                    res_n = s;
                end
            end
        end

        // Register the result and both accumulators.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                res_q    <= '0;
                acc_q[0] <= '0;
                acc_q[1] <= '0;
            end else begin
                res_q    <= res_n;
                acc_q[0] <= acc_n[0];
                acc_q[1] <= acc_n[1];
            end
        end
    end
endmodule

// File: rtl/mac_slice.sv
// Top of the multiply-accumulate slice: input stage, product stage and
// result stage, three cycles from the operands to the result.
// Assumes OP_W is 9, 18 or 36.
module mac_slice
    import mac_slice_pkg::*;
#(
    parameter int OP_W = 18,
    localparam int N     = mults_for(OP_W),
    localparam int PW    = 2 * OP_W,
    localparam int OUT_W = N * PW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_lo,
    input  logic [1:0]        mode_hi,
    input  logic [1:0]        sub_en,
    input  logic [1:0]        acc_clr,
    input  logic              chain_en,
    input  logic              in_valid,
    input  logic [N*OP_W-1:0] a_in,
    input  logic [N*OP_W-1:0] b_in,
    input  logic [OP_W-1:0]   casc_in,
    output logic [OP_W-1:0]   casc_out,
    output logic              out_valid,
    output logic [OUT_W-1:0]  result
);
    ctl_t              ctl0, ctl1, ctl2;
    logic [N*OP_W-1:0] a_q, b_q;
    logic [N*PW-1:0]   p_q;

    assign ctl0 = '{vld: in_valid, m_lo: md_e'(mode_lo), m_hi: md_e'(mode_hi),
                    sub: sub_en, clr: acc_clr};

    mac_slice_in #(.W(OP_W), .N(N)) in_i (
        .clk(clk), .rst_n(rst_n), .chain_en(chain_en), .a_in(a_in), .b_in(b_in),
        .casc_in(casc_in), .ctl_in(ctl0), .a_q(a_q), .b_q(b_q), .ctl_q(ctl1),
        .casc_out(casc_out)
    );

    mac_slice_mul #(.W(OP_W), .N(N)) mul_i (
        .clk(clk), .rst_n(rst_n), .a_q(a_q), .b_q(b_q), .ctl_in(ctl1),
        .p_q(p_q), .ctl_q(ctl2)
    );

    mac_slice_out #(.W(OP_W), .N(N)) out_i (
        .clk(clk), .rst_n(rst_n), .p_q(p_q), .ctl(ctl2),
        .res_q(result), .vld_q(out_valid)
    );
endmodule

// File: rtl/mac_slice_chk.sv
// Checker for the multiply-accumulate slice, bound to the top module.
// Assumes the top module's internal names a_q and ctl2.
module mac_slice_chk #(
    parameter int W     = 18,
    parameter int OUT_W = 144
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             out_valid,
    input logic             chain_en,
    input logic [W-1:0]     casc_in,
    input logic [W-1:0]     tap0,
    input logic             stage2_vld,
    input logic [OUT_W-1:0] result
);
    logic [1:0] since_rst;

    // Count clock edges since reset, saturating at three.
    always_ff @(posedge clk) begin
        if (!rst_n)               since_rst <= 2'd0;
        else if (since_rst != 3)  since_rst <= since_rst + 2'd1;
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R2

    AST_VALID_FROM_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0) && out_valid |-> $past(stage2_vld)); // R2

    AST_TAP0_FROM_CASC: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0) && $past(chain_en) |-> (tap0 == $past(casc_in))); // R9

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0) && !$past(stage2_vld) |-> $stable(result)); // R10
endmodule

bind mac_slice mac_slice_chk #(.W(OP_W), .OUT_W(OUT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
    .chain_en(chain_en), .casc_in(casc_in), .tap0(a_q[OP_W-1:0]),
    .stage2_vld(ctl2.vld), .result(result)
);

// File: tb/mac_slice_tb_top.sv
// Self-checking bench for mac_slice at 18-bit operands.
module mac_slice_tb_top;
    localparam int W  = 18;
    localparam int N  = 4;
    localparam int PW = 2 * W;
    localparam int OW = N * PW;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [1:0]     mode_lo = '0, mode_hi = '0, sub_en = '0, acc_clr = '0;
    logic           chain_en = 1'b0, in_valid = 1'b0;
    logic [N*W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0]   casc_in = '0;
    logic [W-1:0]   casc_out;
    logic           out_valid;
    logic [OW-1:0]  result;

    int n_run = 0, n_fail = 0;

    // Bench reference state.
    logic [W-1:0]  mt [N];
    longint        macc [2];
    logic [OW-1:0] mres;
    logic          pv [3];
    logic [OW-1:0] pr [3];
    string         pt [3];
    string         cur_req;

    always #4 clk = ~clk;

    mac_slice dut_i (
        .clk(clk), .rst_n(rst_n), .mode_lo(mode_lo), .mode_hi(mode_hi),
        .sub_en(sub_en), .acc_clr(acc_clr), .chain_en(chain_en),
        .in_valid(in_valid), .a_in(a_in), .b_in(b_in), .casc_in(casc_in),
        .casc_out(casc_out), .out_valid(out_valid), .result(result)
    );

    task automatic chk(input string tag, input logic [OW-1:0] act, input logic [OW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [OW-1:0] put(input logic [OW-1:0] v, input int lsb,
                                          input int wd, input longint x);
        logic [OW-1:0] r = v;
        for (int i = 0; i < wd; i++) r[lsb+i] = (i < 64) ? x[i] : x[63];
        return r;
    endfunction

    function automatic logic [W-1:0] opnd();
        int r = $urandom % 8;
        case (r)
            0: return 18'h20000;
            1: return 18'h1FFFF;
            2: return '0;
            3: return '1;
            default: return W'($urandom);
        endcase
    endfunction

    function automatic logic [N*W-1:0] rvec();
        logic [N*W-1:0] v;
        for (int k = 0; k < N; k++) v[k*W +: W] = opnd();
        return v;
    endfunction

    // One clock: check the outputs, drive the inputs, advance the reference.
    task automatic step(input logic v, input logic [1:0] mlo, input logic [1:0] mhi,
                        input logic [1:0] sb, input logic [1:0] cl, input logic ch,
                        input logic [W-1:0] cin, input logic [N*W-1:0] av,
                        input logic [N*W-1:0] bv);
        longint p [N];
        longint s;
        @(negedge clk);
        chk("R2 out_valid", {{(OW-1){1'b0}}, out_valid}, {{(OW-1){1'b0}}, pv[2]});
        chk(pt[2], result, pr[2]);
        chk("R9 casc_out", {{(OW-W){1'b0}}, casc_out}, {{(OW-W){1'b0}}, mt[N-1]});
        mode_lo = mlo; mode_hi = mhi; sub_en = sb; acc_clr = cl;
        chain_en = ch; in_valid = v; casc_in = cin; a_in = av; b_in = bv;
        for (int k = N - 1; k >= 0; k--)
            mt[k] = ch ? ((k == 0) ? cin : mt[k-1]) : av[k*W +: W];
        for (int k = 0; k < N; k++)
            p[k] = longint'($signed(mt[k])) * longint'($signed(bv[k*W +: W]));
        if (v) begin
            if (mlo == 2'd3) begin
                s = p[0] + p[2] + (sb[0] ? -p[1] - p[3] : p[1] + p[3]);
                mres = put(mres, 0, OW, s);
            end else begin
                for (int h = 0; h < 2; h++) begin
                    int b = 2 * h;
                    case (h ? mhi : mlo)
                        2'd0: begin
                            mres = put(mres, b*PW, PW, p[b]);
                            mres = put(mres, (b+1)*PW, PW, p[b+1]);
                        end
                        2'd1: begin
                            macc[h] = cl[h] ? p[b] : macc[h] + p[b];
                            macc[h] = (macc[h] <<< 12) >>> 12;
                            mres = put(mres, h*72, 72, macc[h]);
                        end
                        2'd2: mres = put(mres, b*PW, 2*PW, sb[h] ? p[b] - p[b+1] : p[b] + p[b+1]);
                        default: ;
                    endcase
                end
            end
        end
        pv[2] = pv[1]; pr[2] = pr[1]; pt[2] = pt[1];
        pv[1] = pv[0]; pr[1] = pr[0]; pt[1] = pt[0];
        pv[0] = v; pr[0] = mres; pt[0] = v ? cur_req : "R10 hold";
    endtask

    task automatic rnd(input int cycles, input int lo_lim, input int hi_fix, input logic ch);
        for (int i = 0; i < cycles; i++) begin
            logic [1:0] mlo = (lo_lim < 0) ? 2'(-lo_lim - 1) : 2'($urandom % lo_lim);
            logic [1:0] mhi = (hi_fix >= 0) ? 2'(hi_fix) : 2'($urandom % 4);
            logic [1:0] cl  = {($urandom % 8) == 0, ($urandom % 8) == 0};
            step(($urandom % 4) != 0, mlo, mhi, 2'($urandom), cl, ch, opnd(), rvec(), rvec());
        end
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int k = 0; k < N; k++) mt[k] = '0;
        macc[0] = 0; macc[1] = 0; mres = '0;
        for (int i = 0; i < 3; i++) begin pv[i] = 1'b0; pr[i] = '0; pt[i] = "R1 reset"; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out_valid", {{(OW-1){1'b0}}, out_valid}, '0);
        chk("R1 result", result, '0);
        chk("R1 casc_out", {{(OW-W){1'b0}}, casc_out}, '0);
        // R3: extreme operands in multiply mode, then random.
        cur_req = "R3 multiply";
        step(1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, '0, {N{18'h20000}}, {N{18'h20000}});
        step(1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, '0, {N{18'h1FFFF}}, {N{18'h20000}});
        step(1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, '0, {N{18'h3FFFF}}, {N{18'h1FFFF}});
        rnd(200, -1, 0, 1'b0);
        // R4 and R5: accumulate in both halves with random clears.
        cur_req = "R4 R5 accumulate";
        step(1'b1, 2'd1, 2'd1, 2'd0, 2'd3, 1'b0, '0, rvec(), rvec());
        rnd(300, -2, 1, 1'b0);
        // R6: pair add with random subtract.
        cur_req = "R6 pair add";
        rnd(200, -3, 2, 1'b0);
        // R7: four-product sum over the whole slice, high mode irrelevant.
        cur_req = "R7 four-product";
        rnd(200, -4, -1, 1'b0);
        // R8: mixed modes per half.
        cur_req = "R8 mixed halves";
        rnd(400, 3, -1, 1'b0);
        // R9: tap chain fed from casc_in.
        cur_req = "R9 chain";
        rnd(200, -1, 0, 1'b1);
        // R10: idle inputs must not disturb the accumulators or the result.
        cur_req = "R10 after idle";
        step(1'b1, 2'd1, 2'd1, 2'd0, 2'd3, 1'b0, '0, rvec(), rvec());
        for (int i = 0; i < 20; i++)
            step(1'b0, 2'd1, 2'd1, 2'd0, 2'd3, 1'b0, opnd(), rvec(), rvec());
        step(1'b1, 2'd1, 2'd1, 2'd0, 2'd0, 1'b0, '0, rvec(), rvec());
        for (int i = 0; i < 4; i++)
            step(1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, '0, '0, '0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule